// File: doc/BRIEF.md
# Carry-less multiply-add unit

This block computes the carry-less product of two factors, treating them as polynomials over GF(2), and folds a set of extra addend terms into the same result. Each bit of the second factor gates a copy of the first factor, and that copy is shifted left by the bit's position. These shifted copies are then combined with XOR, so no carry ever moves from one bit position to the next.

The partial products and the addend terms all enter one balanced binary XOR tree. The logic depth is therefore one AND level plus about log2(factor width + term count) XOR levels. It does not grow linearly with the operand count. The unit has no clock and no registers. Surrounding logic picks whatever slice of the result it needs, or registers it.

Top module: `clmul_add`

## Requirements
- R1: `result` equals the bit-serial shift-and-XOR product of `factor_a` and `factor_b`, XORed with every addend term zero-extended to `OW` bits. Term k occupies `addends[k*TW +: TW]`.
- R2: When all addend terms are zero, `result` is the plain carry-less product.
- R3: When `factor_b` is 1, `result` equals `factor_a` XORed with the addend terms.
- R4: When either factor is zero, `result` equals the XOR of the addend terms alone.
- R5: Result bits at positions 2*FW-1 and above carry no product contribution. They equal the XOR of the zero-extended terms at those positions.
- R6: Swapping `factor_a` and `factor_b` leaves `result` unchanged.
- R7: With both factors all-ones, `result` has exactly the even bit positions 0..2*FW-2 set (0x555 for FW=6), given zero terms.
- R8: The unit is combinational. `result` reflects new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| factor_a | input | FW | First polynomial factor |
| factor_b | input | FW | Second polynomial factor |
| addends | input | NT*TW | Packed addend terms, term k at bits k*TW upward |
| result | output | OW | Polynomial product XOR addend terms |

## Verification
A wrong partial-product shift or a miswired tree leaf corrupts `result` at once, within the same settle time. No clock is involved. Such an error shows up only for those factor bit patterns that excite the broken leaf. For that reason the bench sweeps every factor pair of the 6-bit configuration, each with varying addends. If the zero-extension of the terms is wrong, the top result bits become nonzero where they should follow the terms. If a tree pairing is mis-indexed, whole terms are dropped, which the zero-factor and unit-factor cases expose.

// File: rtl/clmul_add.sv
module clmul_add #(
  parameter int FW = 6,
  parameter int NT = 2,
  parameter int TW = 8,
  parameter int OW = 2 * FW
) (
  input  logic [FW-1:0]    factor_a,
  input  logic [FW-1:0]    factor_b,
  input  logic [NT*TW-1:0] addends,
  output logic [OW-1:0]    result
);
  localparam int NL = FW + NT;
  localparam int LV = (NL > 1) ? $clog2(NL) : 0;
  localparam int P  = 1 << LV;

  logic [OW-1:0] pprod [FW];

  for (genvar i = 0; i < FW; i++) begin : g_pp
    assign pprod[i] = OW'(factor_a & {FW{factor_b[i]}}) << i;
  end

  for (genvar k = 0; k <= LV; k++) begin : g_lv
    localparam int W = P >> k;
    logic [W*OW-1:0] v;
    if (k == 0) begin : g_leaf
      for (genvar i = 0; i < P; i++) begin : g_in
        if (i < FW) begin : g_p
          assign v[i*OW +: OW] = pprod[i];
        end else if (i < NL) begin : g_t
          assign v[i*OW +: OW] = OW'(addends[(i-FW)*TW +: TW]);
        end else begin : g_z
          assign v[i*OW +: OW] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_x
        assign v[j*OW +: OW] = g_lv[k-1].v[(2*j)*OW +: OW] ^ g_lv[k-1].v[(2*j+1)*OW +: OW];
      end
    end
  end

  assign result = g_lv[LV].v[OW-1:0];
endmodule

// File: rtl/clmul_add_chk.sv
module clmul_add_chk #(
  parameter int FW = 6,
  parameter int NT = 2,
  parameter int TW = 8,
  parameter int OW = 2 * FW
) (
  input logic [FW-1:0]    factor_a,
  input logic [FW-1:0]    factor_b,
  input logic [NT*TW-1:0] addends,
  input logic [OW-1:0]    result
);
  logic [OW-1:0] tx;
  always_comb begin
    tx = '0;
    for (int k = 0; k < NT; k++) tx = tx ^ OW'(addends[k*TW +: TW]);
  end

  always_comb begin
    // R4
    if (factor_a == '0 || factor_b == '0)
      a_r4_zero_factor: assert (result == tx) else $error("a_r4_zero_factor");
    // R3
    if (factor_b == FW'(1))
      a_r3_unit_factor: assert (result == (OW'(factor_a) ^ tx)) else $error("a_r3_unit_factor");
    // R1
    a_r1_low_bit: assert (result[0] == ((factor_a[0] & factor_b[0]) ^ tx[0])) else $error("a_r1_low_bit");
  end

  if (OW > 2*FW-1) begin : g_hi
    always_comb begin
      // R5
      a_r5_high_bits: assert (result[OW-1:2*FW-1] == tx[OW-1:2*FW-1]) else $error("a_r5_high_bits");
    end
  end
endmodule

bind clmul_add clmul_add_chk #(.FW(FW), .NT(NT), .TW(TW), .OW(OW)) u_chk (
  .factor_a(factor_a), .factor_b(factor_b), .addends(addends), .result(result)
);

// File: tb/clmul_add_tb.sv
`timescale 1ns/1ps
module clmul_add_tb;
  localparam int FW = 6, NT = 2, TW = 8, OW = 2 * FW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [FW-1:0] fa, fb;
  logic [NT*TW-1:0] ad;
  logic [OW-1:0] res;
  int n_chk = 0, n_fail = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  clmul_add #(.FW(FW), .NT(NT), .TW(TW), .OW(OW)) u_dut (
    .factor_a(fa), .factor_b(fb), .addends(ad), .result(res)
  );

  function automatic logic [OW-1:0] model(input logic [FW-1:0] a, input logic [FW-1:0] b,
                                          input logic [NT*TW-1:0] t);
    logic [OW-1:0] acc = '0;
    logic [OW-1:0] sh = OW'(a);
    for (int i = 0; i < FW; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh << 1;
    end
    for (int k = 0; k < NT; k++) acc = acc ^ OW'(t[k*TW +: TW]);
    return acc;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h t=%h got=%h exp=%h", req, fa, fb, ad, res, exp);
    end
  endtask

  task automatic apply(input logic [FW-1:0] a, input logic [FW-1:0] b, input logic [NT*TW-1:0] t);
    fa = a; fb = b; ad = t;
    #1;
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    fa = '0; fb = '0; ad = '0;
    #1;
    check("R4 idle", '0);

    for (int a = 0; a < (1 << FW); a++) begin
      for (int b = 0; b < (1 << FW); b++) begin
        lfsr = step(lfsr);
        apply(FW'(a), FW'(b), (NT*TW)'(lfsr));
        check("R1 sweep", model(FW'(a), FW'(b), (NT*TW)'(lfsr)));
        apply(FW'(a), FW'(b), '0);
        check("R2 no addends", model(FW'(a), FW'(b), '0));
      end
    end

    for (int a = 0; a < (1 << FW); a++) begin
      lfsr = step(lfsr);
      apply(FW'(a), FW'(1), (NT*TW)'(lfsr));
      check("R3 unit factor", OW'(a) ^ model('0, '0, (NT*TW)'(lfsr)));
      apply('0, FW'(a), (NT*TW)'(lfsr));
      check("R4 zero factor", model('0, '0, (NT*TW)'(lfsr)));
    end

    apply('1, '1, '1);
    check("R5 high bits", model('1, '1, '1));
    check("R5 top bit zero", {1'b0, res[OW-2:0]});

    for (int i = 0; i < 200; i++) begin
      logic [FW-1:0] a, b;
      logic [OW-1:0] r1;
      lfsr = step(lfsr); a = lfsr[FW-1:0];
      lfsr = step(lfsr); b = lfsr[FW-1:0];
      lfsr = step(lfsr);
      apply(a, b, (NT*TW)'(lfsr));
      r1 = res;
      apply(b, a, (NT*TW)'(lfsr));
      check("R6 swap", r1);
    end

    apply('1, '1, '0);
    check("R7 all ones", 12'h555);

    for (int i = 0; i < FW; i++) begin
      for (int j = 0; j < FW; j++) begin
        fa = FW'(1) << i; fb = FW'(1) << j; ad = '0;
        #0.5;
        check("R8 single bits comb", OW'(1) << (i + j));
        #0.5;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule